// File: doc/BRIEF.md
# Power-On Output Start-Up Sequencer

This block owns an oscillator's output pad from power-on reset until normal oscillation begins. It counts phase ticks, where a phase tick is a one-clock pulse at twice the master oscillator rate, so two ticks make one master period. It keeps the pad floating for the whole start-up interval. It also keeps the pad floating for as long as the divide-code converter has not yet produced a valid code. When both conditions are met, it decides once how to hand the output over. The decision uses the enable input, the float-when-off bit and the divide ratio.

When enable is high at that moment, the pad is driven low for a short lead-in before the divider is started. The lead-in is one master period, which is the same as half an output period when the ratio is 2. When the ratio is 1 it shrinks to half a master period, which is again half an output period. When enable is low, the pad either parks driven low or parks floating, according to the float-when-off bit. It waits in that parked state for enable, then runs the same lead-in. After the lead-in, the divider run signal is raised for good and the sequencer releases the pad.

States:
- `S_BOOT`: counting start-up ticks, pad floating.
- `S_WAIT_CODE`: the interval is over but the code is not yet valid, pad floating.
- `S_PARK_LOW`: parked with the pad driven low.
- `S_PARK_FLOAT`: parked with the pad floating.
- `S_LEAD`: driven-low lead-in.
- `S_RUN`: handed over.

Transitions:
- boot_done: `S_BOOT` to one of the exit states.
- code_ready: `S_WAIT_CODE` to one of the exit states.
- wake: a park state to `S_LEAD`.
- lead_abort: `S_LEAD` back to a park state.
- lead_done: `S_LEAD` to `S_RUN`.

Top module: `startup_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, seq_owns=1, pad_drive=0, pad_force_low=0 and div_run=0. Together these are the FLOAT pattern {seq_owns,pad_drive,pad_force_low,div_run}=1000.
- R2: The pad stays FLOAT through the first BOOT_TICKS-1 phase ticks. It leaves FLOAT at the clock edge that takes the BOOT_TICKS-th tick, provided code_valid=1 then. The default of 1000 ticks equals 500 master periods.
- R3: If code_valid=0 when the interval ends, the pad stays FLOAT whatever ticks arrive. The exit decision is made at the first clock edge that sees code_valid=1.
- R4: If out_enable=1 at the exit decision, the pad goes to LOW, which is the pattern 1110. It stays LOW for a lead-in of 2 ticks when div_log2 (ratio = 2^div_log2) is 1 or more, and 1 tick when div_log2=0. div_run rises at the edge taking the last lead-in tick, giving the pattern RUN = 0001.
- R5: If out_enable=0 and float_when_off=0 at the exit decision, the pad goes to LOW and stays LOW, with ticks ignored, until out_enable=1.
- R6: If out_enable=0 and float_when_off=1 at the exit decision, the pad stays FLOAT, with ticks ignored, until out_enable=1.
- R7: From either parked state, the edge that sees out_enable=1 moves the pad to LOW and starts a full lead-in as in R4.
- R8: If out_enable falls during the lead-in, the next edge parks LOW when float_when_off=0 and FLOAT when it is 1. A later wake restarts the full lead-in.
- R9: Reasserting reset at any point restarts the start-up count from zero.
- R10: Once RUN is reached it holds, and ignores out_enable, float_when_off, code_valid and ticks until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low power-on reset |
| phase_tick | input | 1 | one-clock pulse, two per master period |
| out_enable | input | 1 | output enable request |
| float_when_off | input | 1 | 1: a disabled output floats; 0: it is driven low |
| code_valid | input | 1 | divide code has been settled by the converter |
| div_log2 | input | DIV_W | log2 of the divide ratio |
| seq_owns | output | 1 | sequencer is overriding the pad |
| pad_drive | output | 1 | pad driver enabled (0 = floating) |
| pad_force_low | output | 1 | pad data forced low |
| div_run | output | 1 | divider may run |

## Verification
The exit decision is tried with every mix of enable, float bit, code validity and ratio code. Random draws are combined with directed cases. Together they separate the three exit paths from one another and separate the 1-tick lead-in from the 2-tick one. Late code validity shows that the decision waits for the code and not only for the count. Ticks sent into parked and running states show that those states ignore them. A reset in mid-count shows the count restarts. An enable drop during the lead-in shows the return to parking and a full lead-in on the next wake.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
    typedef enum logic [2:0] {
        S_BOOT,
        S_WAIT_CODE,
        S_PARK_LOW,
        S_PARK_FLOAT,
        S_LEAD,
        S_RUN
    } seq_state_t;
endpackage

// File: rtl/seq_tick_counter.sv
module seq_tick_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] last,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign hit = tick && !clr && (cnt == last);
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import startup_seq_pkg::*;
#(
    parameter int BOOT_TICKS = 1000,
    parameter int DIV_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_tick,
    input  logic             out_enable,
    input  logic             float_when_off,
    input  logic             code_valid,
    input  logic [DIV_W-1:0] div_log2,
    output logic             seq_owns,
    output logic             pad_drive,
    output logic             pad_force_low,
    output logic             div_run
);
    localparam int CNT_W = $clog2(BOOT_TICKS + 1);
    localparam logic [CNT_W-1:0] BOOT_LAST = CNT_W'(BOOT_TICKS - 1);

    seq_state_t state, nxt, exit_choice, park_choice;
    logic boot_hit, lead_hit;
    logic [1:0] lead_last;

    // start-up interval counter, cleared outside S_BOOT
    seq_tick_counter #(.W(CNT_W)) u_boot_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != S_BOOT),
        .tick  (phase_tick),
        .last  (BOOT_LAST),
        .hit   (boot_hit)
    );

    // lead-in: half a master period for ratio 1, one master period otherwise
    assign lead_last = (div_log2 == '0) ? 2'd0 : 2'd1;

    seq_tick_counter #(.W(2)) u_lead_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != S_LEAD),
        .tick  (phase_tick),
        .last  (lead_last),
        .hit   (lead_hit)
    );

    always_comb begin
        park_choice = float_when_off ? S_PARK_FLOAT : S_PARK_LOW;
        if (!code_valid)
            exit_choice = S_WAIT_CODE;
        else if (out_enable)
            exit_choice = S_LEAD;
        else
            exit_choice = park_choice;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:       if (boot_hit) nxt = exit_choice;
            S_WAIT_CODE:  nxt = exit_choice;
            S_PARK_LOW,
            S_PARK_FLOAT: if (out_enable) nxt = S_LEAD;
            S_LEAD: begin
                if (!out_enable)
                    nxt = park_choice;
                else if (lead_hit)
                    nxt = S_RUN;
            end
            S_RUN:        nxt = S_RUN;
            default:      nxt = S_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_BOOT;
        else
            state <= nxt;
    end

    always_comb begin
        seq_owns      = 1'b1;
        pad_drive     = 1'b0;
        pad_force_low = 1'b0;
        div_run       = 1'b0;
        unique case (state)
            S_BOOT, S_WAIT_CODE, S_PARK_FLOAT: ;
            S_PARK_LOW, S_LEAD: begin
                pad_drive     = 1'b1;
                pad_force_low = 1'b1;
            end
            S_RUN: begin
                seq_owns = 1'b0;
                div_run  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic code_valid,
    input logic seq_owns,
    input logic pad_drive,
    input logic pad_force_low,
    input logic div_run
);
    // R10
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_run |=> div_run);

    // R10
    run_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_run) |-> !seq_owns && !pad_drive);

    // R3
    drive_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_drive) |-> $past(code_valid));

    // R4
    lead_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_run) |-> $past(pad_drive && pad_force_low));

    // R1
    always @(posedge clk)
        if (!rst_n)
            reset_float_chk: assert (seq_owns && !pad_drive && !div_run);
endmodule

bind startup_sequencer startup_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .code_valid    (code_valid),
    .seq_owns      (seq_owns),
    .pad_drive     (pad_drive),
    .pad_force_low (pad_force_low),
    .div_run       (div_run)
);

// File: tb/sim_startup_sequencer.sv
module sim_startup_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int T = 12;
    localparam logic [3:0] FLOAT = 4'b1000, LOW = 4'b1110, RUN = 4'b0001;

    logic clk = 0, rst_n = 0, phase_tick = 0, out_enable = 0;
    logic float_when_off = 0, code_valid = 0;
    logic [2:0] div_log2 = 0;
    logic seq_owns, pad_drive, pad_force_low, div_run;
    int checks = 0, failures = 0;

    startup_sequencer #(.BOOT_TICKS(T), .DIV_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick),
        .out_enable(out_enable), .float_when_off(float_when_off),
        .code_valid(code_valid), .div_log2(div_log2),
        .seq_owns(seq_owns), .pad_drive(pad_drive),
        .pad_force_low(pad_force_low), .div_run(div_run)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lead_len(input logic [2:0] d);
        return (d == 0) ? 1 : 2;
    endfunction

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {seq_owns, pad_drive, pad_force_low, div_run};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) phase_tick = 1;
            @(negedge clk) phase_tick = 0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 in reset", FLOAT);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", FLOAT);
    endtask

    task automatic lead_then_run(input logic [2:0] d);
        chk("R4 lead low", LOW);
        ticks(lead_len(d) - 1);
        chk("R4 lead still low", LOW);
        ticks(1);
        chk("R4 run", RUN);
        out_enable = ~out_enable; float_when_off = ~float_when_off; code_valid = 0;
        ticks(3);
        chk("R10 run held", RUN);
    endtask

    task automatic run_case(input logic oe, input logic hz, input logic cv, input logic [2:0] d);
        out_enable = oe; float_when_off = hz; code_valid = cv; div_log2 = d;
        do_reset();
        ticks(T - 1);
        chk("R2 before end", FLOAT);
        ticks(1);
        if (!cv) begin
            chk("R3 no code", FLOAT);
            ticks(2);
            chk("R3 no code ticks", FLOAT);
            code_valid = 1;
            @(negedge clk);
        end
        if (oe) begin
            lead_then_run(d);
        end else begin
            chk(hz ? "R6 park float" : "R5 park low", hz ? FLOAT : LOW);
            ticks(3);
            chk(hz ? "R6 float held" : "R5 low held", hz ? FLOAT : LOW);
            out_enable = 1;
            @(negedge clk);
            chk("R7 wake", LOW);
            lead_then_run(d);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(7));
        // directed corners
        run_case(1, 0, 1, 0);
        run_case(1, 1, 1, 5);
        run_case(0, 0, 1, 0);
        run_case(0, 1, 1, 7);
        run_case(1, 0, 0, 2);
        run_case(0, 1, 0, 0);
        // R9: reset in mid-count restarts the interval
        out_enable = 1; float_when_off = 0; code_valid = 1; div_log2 = 3;
        do_reset();
        ticks(T - 2);
        do_reset();
        ticks(T - 1);
        chk("R9 restart count", FLOAT);
        ticks(1);
        // R8: enable drop during lead-in
        ticks(1);
        out_enable = 0;
        @(negedge clk);
        chk("R8 abort to low park", LOW);
        ticks(2);
        chk("R8 parked", LOW);
        out_enable = 1;
        @(negedge clk);
        ticks(1);
        chk("R8 full lead restarted", LOW);
        ticks(1);
        chk("R8 run after lead", RUN);
        float_when_off = 1; div_log2 = 1;
        do_reset();
        ticks(T);
        out_enable = 0;
        @(negedge clk);
        chk("R8 abort to float park", FLOAT);
        // random mix
        for (int k = 0; k < 16; k++)
            run_case(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule